// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block translates 32-bit virtual addresses into physical addresses for a processor core, using 4 KB pages. It keeps a small, fully associative set of recently used page mappings. Every lookup yields one registered response. The response either carries a physical address, built from the stored frame number and the untouched 12-bit page offset, or it raises a fault. A fault means either that no mapping is cached, or that the cached mapping forbids the kind of access requested.

Nothing walks page tables in hardware. When a fault occurs, software decides what to do and installs a mapping through the fill port. If the page is already cached, the fill rewrites that entry in place. Otherwise the fill takes the slot named by a round-robin pointer. Each entry carries a writable flag, a user-access flag, and cacheable and bufferable attributes. The attributes are returned on a permitted hit. A single invalidate input empties the whole buffer in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: A response appears on the clock edge after a lookup is presented. `rsp_valid` is high for exactly the cycles that follow a cycle with `lk_valid` high.
- R2: A permitted hit returns `rsp_paddr = {stored frame, lk_vaddr[11:0]}`, `rsp_hit=1`, `rsp_fault=0`, `rsp_cause=2'b00`, and the entry's cacheable and bufferable bits.
- R3: A lookup whose page matches no valid entry returns `rsp_fault=1`, `rsp_cause=2'b01`, `rsp_hit=0`, and zero on the address and attribute outputs.
- R4: A write (`lk_write=1`) to an entry whose writable flag is 0 returns `rsp_fault=1`, `rsp_cause=2'b10` and `rsp_hit=1`, with zero address and attributes.
- R5: A user-mode access (`lk_user=1`) to an entry whose user flag is 0 returns `rsp_cause=2'b11`. This code wins when the access is also a forbidden write.
- R6: Kernel-mode accesses ignore the user flag, and reads ignore the writable flag.
- R7: A fill whose page is already cached overwrites that entry and does not advance the replacement pointer.
- R8: A fill of a new page writes the slot at the replacement pointer, which then advances and wraps after 64 slots. The 65th distinct fill after reset therefore evicts the first.
- R9: `inv_all` clears every entry at the next edge. A lookup in the same cycle still sees the old contents, a lookup in the next cycle misses, and a fill in the same cycle is dropped.
- R10: Reset empties the buffer, zeroes the replacement pointer and holds `rsp_valid`, `rsp_hit` and `rsp_fault` low.
- R11: A lookup presented in the same cycle as a fill of its page sees the buffer as it was before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| fill_en | input | 1 | Install a mapping this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number for that page |
| fill_wr_ok | input | 1 | Page may be written |
| fill_user_ok | input | 1 | Page may be accessed from user mode |
| fill_cache | input | 1 | Cacheable attribute |
| fill_bufferable | input | 1 | Bufferable attribute |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_hit | output | 1 | A valid entry matched the page |
| rsp_fault | output | 1 | Page fault |
| rsp_cause | output | 2 | 00 none, 01 miss, 10 write forbidden, 11 privilege |
| rsp_cache | output | 1 | Cacheable attribute of the hit |
| rsp_bufferable | output | 1 | Bufferable attribute of the hit |

## Verification
Every response is due exactly one clock edge after its lookup. The bench therefore drives a lookup on a falling edge and samples all response outputs on the next falling edge. It then checks on the falling edge after that that `rsp_valid` has dropped. Fills and invalidates take effect at the edge that captures them, so a lookup issued one falling edge later already sees the new contents. The R9 and R11 cases instead present a lookup in the very cycle of the fill or invalidate, and they expect the old contents in that response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_MISS  = 2'b01,
    CAUSE_WRITE = 2'b10,
    CAUSE_PRIV  = 2'b11
  } cause_e;

  typedef struct packed {
    logic wr_ok;
    logic user_ok;
    logic cache;
    logic bufferable;
  } attr_t;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]              key,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  output logic                          any,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end

  // fills never create duplicates, so at most one bit is set
  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |hit_vec;
endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (advance) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          we,
  input  logic [IDX_W-1:0]              widx,
  input  logic [VPN_W-1:0]              wvpn,
  input  logic [PFN_W-1:0]              wpfn,
  input  attr_t                         wattr,
  output logic [ENTRIES-1:0]            valid,
  output logic [ENTRIES-1:0][VPN_W-1:0] tags,
  output logic [ENTRIES-1:0][PFN_W-1:0] pfns,
  output attr_t [ENTRIES-1:0]           attrs
);
  always_ff @(posedge clk) begin
    if (rst || clear) valid <= '0;
    else if (we) valid[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tags[widx]  <= wvpn;
      pfns[widx]  <= wpfn;
      attrs[widx] <= wattr;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 64,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PFN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             lk_user,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr_ok,
  input  logic             fill_user_ok,
  input  logic             fill_cache,
  input  logic             fill_bufferable,
  input  logic             inv_all,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic             rsp_cache,
  output logic             rsp_bufferable
);
  logic [ENTRIES-1:0]            valid;
  logic [ENTRIES-1:0][VPN_W-1:0] tags;
  logic [ENTRIES-1:0][PFN_W-1:0] pfns;
  attr_t [ENTRIES-1:0]           attrs;

  logic             lk_any, fill_any;
  logic [IDX_W-1:0] lk_idx, fill_idx, vptr;
  logic             fill_go;
  attr_t            fill_attr, sel_attr;
  cause_e           cause;

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .key(lk_vaddr[VA_W-1:PAGE_BITS]), .valid(valid), .tags(tags),
    .any(lk_any), .idx(lk_idx)
  );

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
    .key(fill_vpn), .valid(valid), .tags(tags),
    .any(fill_any), .idx(fill_idx)
  );

  // invalidate wins over a fill in the same cycle
  assign fill_go   = fill_en && !inv_all;
  assign fill_attr = '{wr_ok: fill_wr_ok, user_ok: fill_user_ok,
                       cache: fill_cache, bufferable: fill_bufferable};

  tlb_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .advance(fill_go && !fill_any), .ptr(vptr)
  );

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk(clk), .rst(rst), .clear(inv_all), .we(fill_go),
    .widx(fill_any ? fill_idx : vptr), .wvpn(fill_vpn), .wpfn(fill_pfn),
    .wattr(fill_attr), .valid(valid), .tags(tags), .pfns(pfns), .attrs(attrs)
  );

  assign sel_attr = attrs[lk_idx];

  // privilege is checked ahead of write permission
  always_comb begin
    if (!lk_any)                          cause = CAUSE_MISS;
    else if (lk_user && !sel_attr.user_ok) cause = CAUSE_PRIV;
    else if (lk_write && !sel_attr.wr_ok)  cause = CAUSE_WRITE;
    else                                  cause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_hit        <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_cause      <= CAUSE_NONE;
      rsp_cache      <= 1'b0;
      rsp_bufferable <= 1'b0;
    end else begin
      rsp_valid      <= lk_valid;
      rsp_hit        <= lk_valid && lk_any;
      rsp_fault      <= lk_valid && (cause != CAUSE_NONE);
      rsp_cause      <= lk_valid ? cause : CAUSE_NONE;
      if (lk_valid && cause == CAUSE_NONE) begin
        rsp_paddr      <= {pfns[lk_idx], lk_vaddr[PAGE_BITS-1:0]};
        rsp_cache      <= sel_attr.cache;
        rsp_bufferable <= sel_attr.bufferable;
      end else begin
        rsp_paddr      <= '0;
        rsp_cache      <= 1'b0;
        rsp_bufferable <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_checker.sv
module tlb_xlate_checker #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            inv_all,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_hit,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause,
  input logic            rsp_cache,
  input logic            rsp_bufferable
);
  // R1: one response per lookup, one cycle later
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  // R2: a clean response keeps the page offset and reports a hit
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (rsp_fault || (rsp_hit && rsp_cause == 2'b00 &&
                  rsp_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0]))));

  // R3: a miss carries no hit and no address
  a_r3_miss_empty: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_cause == 2'b01) |-> (rsp_fault && !rsp_hit && rsp_paddr == '0));

  // R4 / R5: any fault blanks address and attributes and names a cause
  a_r4_fault_blank: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_cache &&
                                  !rsp_bufferable && rsp_cause != 2'b00));

  // R9: a lookup right after invalidate misses
  a_r9_inv_then_miss: assert property (@(posedge clk) disable iff (rst)
    (inv_all ##1 lk_valid) |=> (rsp_cause == 2'b01));

  // R10: idle outputs stay quiet
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_fault));
endmodule

bind tlb_xlate tlb_xlate_checker #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .inv_all(inv_all),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit),
  .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_cache(rsp_cache),
  .rsp_bufferable(rsp_bufferable)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        fill_en = 1'b0, fill_wr_ok = 1'b0, fill_user_ok = 1'b0;
  logic        fill_cache = 1'b0, fill_bufferable = 1'b0, inv_all = 1'b0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_cache, rsp_bufferable;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_user(lk_user), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_wr_ok(fill_wr_ok),
    .fill_user_ok(fill_user_ok), .fill_cache(fill_cache),
    .fill_bufferable(fill_bufferable), .inv_all(inv_all),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_cache(rsp_cache),
    .rsp_bufferable(rsp_bufferable)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // packed response: {valid, hit, fault, cause, cache, buf, paddr}
  function automatic logic [63:0] pack_rsp();
    return {25'd0, rsp_valid, rsp_hit, rsp_fault, rsp_cause, rsp_cache, rsp_bufferable, rsp_paddr};
  endfunction

  function automatic logic [63:0] exp_rsp(input logic h, input logic f, input logic [1:0] c,
                                          input logic ca, input logic bu, input logic [31:0] pa);
    return {25'd0, 1'b1, h, f, c, ca, bu, pa};
  endfunction

  task automatic drive_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                            input logic w, input logic u, input logic c, input logic b);
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
    fill_wr_ok = w; fill_user_ok = u; fill_cache = c; fill_bufferable = b;
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                         input logic w, input logic u, input logic c, input logic b);
    drive_fill(vpn, pfn, w, u, c, b);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // lookup, then compare the response on the next falling edge
  task automatic look(input string tag, input logic [31:0] va, input logic wr, input logic usr,
                      input logic [63:0] exp);
    lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_user = usr;
    @(negedge clk);
    chk(tag, pack_rsp(), exp);
    lk_valid = 1'b0;
    fill_en = 1'b0; inv_all = 1'b0;
  endtask

  task automatic pulse_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    look("R10/R3 empty after reset", 32'h1234_5678, 1'b0, 1'b0, exp_rsp(0, 1, 2'b01, 0, 0, 32'h0));
  endtask

  task automatic t_hit();
    do_fill(20'h12345, 20'h00ABC, 1'b1, 1'b1, 1'b1, 1'b0);
    look("R2 user read hit", 32'h1234_5678, 1'b0, 1'b1, exp_rsp(1, 0, 2'b00, 1, 0, 32'h00AB_C678));
    @(negedge clk);
    chk("R1 rsp_valid drops", {63'd0, rsp_valid}, 64'd0);
    look("R2 user write hit", 32'h1234_5FFF, 1'b1, 1'b1, exp_rsp(1, 0, 2'b00, 1, 0, 32'h00AB_CFFF));
  endtask

  task automatic t_perm();
    do_fill(20'h20000, 20'h0F00D, 1'b0, 1'b0, 1'b0, 1'b1);
    do_fill(20'h20001, 20'h0BEEF, 1'b0, 1'b1, 1'b1, 1'b1);
    look("R6 kernel read of kernel page", 32'h2000_0010, 1'b0, 1'b0, exp_rsp(1, 0, 2'b00, 0, 1, 32'h0F00_D010));
    look("R4 kernel write read-only", 32'h2000_0010, 1'b1, 1'b0, exp_rsp(1, 1, 2'b10, 0, 0, 32'h0));
    look("R5 user read kernel page", 32'h2000_0010, 1'b0, 1'b1, exp_rsp(1, 1, 2'b11, 0, 0, 32'h0));
    look("R5 user write kernel ro page", 32'h2000_0010, 1'b1, 1'b1, exp_rsp(1, 1, 2'b11, 0, 0, 32'h0));
    look("R6 user read user ro page", 32'h2000_1ABC, 1'b0, 1'b1, exp_rsp(1, 0, 2'b00, 1, 1, 32'h0BEE_FABC));
    look("R4 user write user ro page", 32'h2000_1ABC, 1'b1, 1'b1, exp_rsp(1, 1, 2'b10, 0, 0, 32'h0));
  endtask

  task automatic t_miss();
    look("R3 unmapped page", 32'h3000_0004, 1'b0, 1'b0, exp_rsp(0, 1, 2'b01, 0, 0, 32'h0));
  endtask

  task automatic t_same_cycle_fill();
    drive_fill(20'h55555, 20'h01111, 1'b1, 1'b1, 1'b0, 1'b0);
    look("R11 lookup sees pre-fill state", 32'h5555_5000, 1'b0, 1'b0, exp_rsp(0, 1, 2'b01, 0, 0, 32'h0));
    look("R11 lookup after fill", 32'h5555_5000, 1'b0, 1'b0, exp_rsp(1, 0, 2'b00, 0, 0, 32'h0111_1000));
  endtask

  task automatic t_invalidate();
    inv_all = 1'b1;
    drive_fill(20'h66666, 20'h02222, 1'b1, 1'b1, 1'b0, 1'b0);
    look("R9 lookup during invalidate sees old", 32'h1234_5001, 1'b0, 1'b1, exp_rsp(1, 0, 2'b00, 1, 0, 32'h00AB_C001));
    look("R9 entry gone after invalidate", 32'h1234_5001, 1'b0, 1'b1, exp_rsp(0, 1, 2'b01, 0, 0, 32'h0));
    look("R9 fill beside invalidate dropped", 32'h6666_6000, 1'b0, 1'b0, exp_rsp(0, 1, 2'b01, 0, 0, 32'h0));
  endtask

  task automatic t_replace();
    do_fill(20'h12345, 20'h00ABC, 1'b1, 1'b1, 1'b0, 1'b0);
    pulse_reset();
    look("R10 reset empties buffer", 32'h1234_5000, 1'b0, 1'b0, exp_rsp(0, 1, 2'b01, 0, 0, 32'h0));
    do_fill(20'hAAAAA, 20'h00001, 1'b1, 1'b1, 1'b0, 1'b0);
    do_fill(20'hAAAAA, 20'h00002, 1'b1, 1'b1, 1'b0, 1'b0);
    look("R7 in-place update", 32'hAAAA_A000, 1'b0, 1'b0, exp_rsp(1, 0, 2'b00, 0, 0, 32'h0000_2000));
    for (int i = 0; i < 63; i++) begin
      do_fill(20'h40000 + 20'(i), 20'h10000 + 20'(i), 1'b1, 1'b1, 1'b0, 1'b0);
    end
    look("R7 pointer held on update", 32'hAAAA_A000, 1'b0, 1'b0, exp_rsp(1, 0, 2'b00, 0, 0, 32'h0000_2000));
    look("R8 last slot filled", 32'h4003_E000, 1'b0, 1'b0, exp_rsp(1, 0, 2'b00, 0, 0, 32'h1003_E000));
    do_fill(20'h77777, 20'h03333, 1'b1, 1'b1, 1'b0, 1'b0);
    look("R8 oldest evicted", 32'hAAAA_A000, 1'b0, 1'b0, exp_rsp(0, 1, 2'b01, 0, 0, 32'h0));
    look("R8 second oldest kept", 32'h4000_0000, 1'b0, 1'b0, exp_rsp(1, 0, 2'b00, 0, 0, 32'h1000_0000));
    look("R8 newcomer present", 32'h7777_7123, 1'b0, 1'b0, exp_rsp(1, 0, 2'b00, 0, 0, 32'h0333_3123));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hit();
    t_perm();
    t_miss();
    t_same_cycle_fill();
    t_invalidate();
    t_replace();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule